// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor request port and a main-memory port and keeps a small direct-mapped cache of memory words. Each line holds one tag, one valid bit and one data word. The low bits of a processor address pick the line, and the remaining upper bits are stored and compared to decide whether the access hits. A read that hits is answered from the data array and does not touch memory. A read that misses always fetches the word from memory. A write always goes to memory.

Allocation is decided per access by a cacheability input, which the system drives combinationally (for example, from an address-range compare). The block samples it together with the request. For a cacheable miss, the fetched word is also written into the line. For a non-cacheable miss, the line is left as it is. A cacheable write updates the line along with memory. A non-cacheable write sends the data to memory only, and it clears the valid bit if the line currently matches, so no stale copy remains.

The processor side is a valid/ready request port. `cpu_req_ready` is high only while the controller is idle, so at most one request is in flight. A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. Completion is a single-cycle `cpu_done` pulse, and `cpu_rdata` is valid during that pulse for reads. The memory side holds its read or write strobe, with a stable address and write data, until it samples `mem_ready` high. Memory back-pressure is therefore any number of cycles with `mem_ready` low.

Top module: `wt_cache_ctrl`

## Requirements
- R1: With the default IDX_W=3, the line index is `addr[2:0]` and the tag is `addr[7:3]`. Two addresses with the same index and different tags evict each other.
- R2: A read hits only when the indexed valid bit is set and the stored tag equals the address tag. A read hit completes with no memory read handshake, and `cpu_done` goes high two clock edges after acceptance with the cached word on `cpu_rdata`.
- R3: Reset clears every valid bit. After reset `cpu_req_ready` is 1 and `cpu_done`, `mem_rd` and `mem_wr` are 0, and the first read of any address misses.
- R4: A cacheable read miss performs exactly one memory read at the request address, returns the memory word, and fills the line so that the next read of that address hits.
- R5: A non-cacheable read miss performs exactly one memory read and returns its word without filling the line, so a repeat read misses again.
- R6: Every write performs exactly one memory write handshake, carrying the request address and data.
- R7: A cacheable write stores tag, data and a set valid bit in the line, so a following read of that address hits and returns the written data.
- R8: A non-cacheable write whose line currently matches clears that line's valid bit, so the next read of that address misses and returns the memory contents.
- R9: While `mem_rd` or `mem_wr` is high and `mem_ready` is low, the strobe stays high on the next cycle and `mem_addr` stays unchanged. `mem_rd` and `mem_wr` are never high together.
- R10: `cpu_req_ready` is low from the edge that accepts a request until the cycle after `cpu_done`.
- R11: `cpu_done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle and able to accept |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_cacheable | input | 1 | 1 = allocate on this access, sampled with the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| mem_rd | output | 1 | Memory read strobe, held until ready |
| mem_wr | output | 1 | Memory write strobe, held until ready |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, sampled with ready |
| mem_ready | input | 1 | Memory completes the strobed access |

## Verification
The assertions assume that memory raises `mem_ready` only while a strobe is up and returns valid `mem_rdata` in that same cycle. They also assume that `cpu_req_cacheable` is meaningful only in the cycle a request is accepted. The bench's memory responder follows both assumptions. It counts a chosen latency of zero to two cycles after the strobe rises, raises ready for exactly one cycle, and drops it right after the handshake. The processor driver presents a request only while ready is high and removes it after one accepting edge. This keeps the one-request-at-a-time rule intact while the sweep varies latency, cacheability, direction and conflicting tags.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_MRD   = 3'd2,
    ST_MWR   = 3'd3,
    ST_DONE  = 3'd4
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic             inval_en,
  output logic             hit
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[lk_idx] <= 1'b1;
    end else if (inval_en) begin
      vld_q[lk_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_idx] <= lk_tag;
  end

  assign hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R8
  inval_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (inval_en && !fill_en) |=> !hit);

  // R7
  fill_sets_hit_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> hit);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[idx] <= wdata;
  end

  assign rdata = word_q[idx];
endmodule

// File: rtl/wtc_ctrl_fsm.sv
module wtc_ctrl_fsm
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic op_write,
  input  logic op_cacheable,
  input  logic hit,
  input  logic mem_ready,
  output logic req_ready,
  output logic mem_rd,
  output logic mem_wr,
  output logic fill_en,
  output logic fill_from_mem,
  output logic inval_en,
  output logic ld_cache,
  output logic ld_mem,
  output logic done
);
  wtc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_LOOK;
      ST_LOOK: begin
        if (op_write)  st_d = ST_MWR;
        else if (hit)  st_d = ST_DONE;
        else           st_d = ST_MRD;
      end
      ST_MRD:  if (mem_ready) st_d = ST_DONE;
      ST_MWR:  if (mem_ready) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_rd        = (st_q == ST_MRD);
  assign mem_wr        = (st_q == ST_MWR);
  assign done          = (st_q == ST_DONE);
  assign ld_cache      = (st_q == ST_LOOK) && !op_write && hit;
  assign ld_mem        = (st_q == ST_MRD) && mem_ready;
  assign fill_from_mem = (st_q == ST_MRD);
  assign fill_en       = (st_q == ST_MRD || st_q == ST_MWR) && mem_ready && op_cacheable;
  assign inval_en      = (st_q == ST_MWR) && mem_ready && !op_cacheable && hit;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> mem_rd);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> mem_wr);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    ld_cache |=> (done && !mem_rd));
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  input  logic              cpu_req_cacheable,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, line_word, fill_word;
  logic              write_q, cach_q;
  logic              hit, fill_en, fill_from_mem, inval_en, ld_cache, ld_mem;
  logic              accept;

  assign accept = cpu_req_valid && cpu_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      cach_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= cpu_req_addr;
      wdata_q <= cpu_req_wdata;
      write_q <= cpu_req_write;
      cach_q  <= cpu_req_cacheable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (ld_cache) rdata_q <= line_word;
    else if (ld_mem)   rdata_q <= mem_rdata;
  end

  assign fill_word = fill_from_mem ? mem_rdata : wdata_q;

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_idx   (addr_q[IDX_W-1:0]),
    .lk_tag   (addr_q[ADDR_W-1:IDX_W]),
    .fill_en  (fill_en),
    .inval_en (inval_en),
    .hit      (hit)
  );

  wtc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .wr_en (fill_en),
    .idx   (addr_q[IDX_W-1:0]),
    .wdata (fill_word),
    .rdata (line_word)
  );

  wtc_ctrl_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (cpu_req_valid),
    .op_write      (write_q),
    .op_cacheable  (cach_q),
    .hit           (hit),
    .mem_ready     (mem_ready),
    .req_ready     (cpu_req_ready),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .fill_en       (fill_en),
    .fill_from_mem (fill_from_mem),
    .inval_en      (inval_en),
    .ld_cache      (ld_cache),
    .ld_mem        (ld_mem),
    .done          (cpu_done)
  );

  assign cpu_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ready) |=> $stable(mem_addr));

  // R6
  wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> $stable(mem_wdata));
endmodule

// File: tb/wt_cache_ctrl_tb.sv
`timescale 1ns/1ps
module wt_cache_ctrl_tb;
  localparam int AW = 8, DW = 16, IW = 3, LINES = 1 << IW;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_cach = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rdata, mem_wdata, mem_rdata;
  logic done, mem_rd, mem_wr, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;

  int vectors = 0, errors = 0, lat = 0, rcnt = 0;
  logic [DW-1:0] bmem [1<<AW];
  logic [DW-1:0] m_mem [1<<AW];
  logic          m_vld [LINES];
  logic [AW-IW-1:0] m_tag [LINES];
  logic [DW-1:0] m_dat [LINES];

  always #10 clk = ~clk;

  wt_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .cpu_req_valid(req_valid), .cpu_req_ready(req_ready),
    .cpu_req_write(req_write), .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_req_cacheable(req_cach), .cpu_done(done), .cpu_rdata(rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      rcnt <= 0;
      if (mem_wr) bmem[mem_addr] <= mem_wdata;
    end else if (mem_rd || mem_wr) begin
      if (rcnt >= lat) mem_ready <= 1'b1;
      else rcnt <= rcnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LINES; i++) m_vld[i] = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !mem_rd && !mem_wr, "R3 idle outputs after reset",
        {req_ready, done, mem_rd, mem_wr}, 4'b1000);
  endtask

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic cach, input int l);
    int idx, rds, wrs, cyc, gap;
    logic hit, seen;
    logic [DW-1:0] exp;
    idx = int'(a[IW-1:0]);
    hit = m_vld[idx] && (m_tag[idx] == a[AW-1:IW]);
    lat = l;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_cach = cach;
    @(negedge clk);
    req_valid = 1'b0; req_cach = 1'b0;
    rds = 0; wrs = 0; cyc = 1; seen = 1'b0; gap = 0;
    while (!seen && cyc < 40) begin
      if (done) begin
        seen = 1'b1;
      end else begin
        if (req_ready) gap++;
        if (mem_rd && mem_ready) begin
          rds++;
          chk(mem_addr == a, "R4 read address", mem_addr, a);
        end
        if (mem_wr && mem_ready) begin
          wrs++;
          chk(mem_addr == a && mem_wdata == d, "R6 write addr/data", mem_wdata, d);
        end
        @(negedge clk);
        cyc++;
      end
    end
    chk(seen, "R11 done seen", seen, 1);
    chk(gap == 0, "R10 ready low while busy", gap, 0);
    if (wr) begin
      chk(wrs == 1 && rds == 0, "R6 one memory write", wrs, 1);
      m_mem[a] = d;
      if (cach) begin
        m_vld[idx] = 1'b1; m_tag[idx] = a[AW-1:IW]; m_dat[idx] = d;
      end else if (hit) begin
        m_vld[idx] = 1'b0;
      end
    end else begin
      if (hit) begin
        exp = m_dat[idx];
        chk(rds == 0 && cyc == 2, "R2 hit no memory, done after 2 edges", rds, 0);
      end else begin
        exp = m_mem[a];
        chk(rds == 1, cach ? "R4 cacheable miss one read" : "R5 uncached miss one read", rds, 1);
        if (cach) begin
          m_vld[idx] = 1'b1; m_tag[idx] = a[AW-1:IW]; m_dat[idx] = exp;
        end
      end
      chk(rdata == exp, hit ? "R2 hit data" : "R4 R5 miss data", rdata, exp);
    end
    @(negedge clk);
    chk(!done && req_ready, "R11 done single cycle", done, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      bmem[i] = DW'(i * 1000 + 7);
      m_mem[i] = bmem[i];
    end
    @(negedge clk);
    do_reset();
    // R3: every first read after reset misses
    do_op(1'b0, 8'h05, '0, 1'b1, 0);
    // R4 then R2: second read hits
    do_op(1'b0, 8'h05, '0, 1'b1, 1);
    // R1: same index, other tag evicts line
    do_op(1'b0, 8'h0D, '0, 1'b1, 2);
    do_op(1'b0, 8'h05, '0, 1'b1, 0);
    // R5: uncached read twice, both miss
    do_op(1'b0, 8'h22, '0, 1'b0, 1);
    do_op(1'b0, 8'h22, '0, 1'b0, 0);
    // R7: cacheable write then hit with new data
    do_op(1'b1, 8'h13, 16'hBEEF, 1'b1, 2);
    do_op(1'b0, 8'h13, '0, 1'b0, 0);
    // R8: uncached write to matching line invalidates
    do_op(1'b1, 8'h13, 16'h1234, 1'b0, 1);
    do_op(1'b0, 8'h13, '0, 1'b0, 0);
    // R3: reset in mid-run clears the filled lines
    do_op(1'b0, 8'h05, '0, 1'b1, 0);
    do_reset();
    do_op(1'b0, 8'h05, '0, 1'b1, 0);
    // sweep over 32 addresses (4 tags x 8 lines), all op kinds and latencies
    for (int i = 0; i < 900; i++) begin
      do_op((i % 3) == 0, AW'((i * 29 + i / 7) & 31), DW'(i * 97 + 5),
            ((i / 5) % 4) != 0, i % 3);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule